// File: doc/BRIEF.md
# Buffered Serial Byte Transmitter

This block turns bytes written in parallel by a processor into asynchronous serial frames on a single output line. The writer presents a byte together with a write strobe. The byte enters a sixteen-entry first-in first-out buffer and then moves through two further stages. The first is a one-byte holding stage. The second is an eleven-bit framing shift register. Each stage takes a new byte only when it has become empty.

Every frame has the following bits, and every bit lasts the same number of system clocks:

- a low start bit;
- the eight data bits, least significant bit first;
- an even parity bit;
- a high stop bit.

A counter divides the system clock to set the bit length. The default ratio suits a 50 MHz clock and a line rate of 9600 bits per second. A simulation can override it with a small ratio.

When more data is waiting, frames follow one another with no gap. Otherwise the line rests high.

The writer watches two flags. The full flag tells it to hold off. The idle flag tells it that every stage is empty and the line is quiet.

Top module: `uart_tx_pipe`

## Requirements
- R1: After reset, `tx_line` is 1, `fifo_full` is 0 and `tx_idle` is 1.
- R2: A byte on `wr_data` is accepted at a rising clock edge where `wr_en` is 1 and `fifo_full` is 0. Accepted bytes leave the line in the order they were written.
- R3: The buffer holds 16 bytes. `fifo_full` is 1 exactly when no buffer entry is free. Starting from idle with writes on every cycle, 18 bytes are accepted before `fifo_full` rises: 16 in the buffer, one in the holding stage and one in the framing stage.
- R4: A write while `fifo_full` is 1 is dropped. It leaves the buffer contents unchanged and never appears on the line.
- R5: A frame is 11 bits in this order:
  - start bit 0;
  - data bit 0 through data bit 7;
  - parity bit, equal to the XOR of the 8 data bits;
  - stop bit 1.
- R6: Every bit of a frame holds the line for exactly `CLK_DIV` clock cycles, so one frame lasts 11*`CLK_DIV` cycles.
- R7: When the block is idle, the start bit of a written byte appears on `tx_line` in the cycle after the second rising edge that follows the write edge.
- R8: When another byte is waiting as a stop bit ends, its start bit begins in the very next cycle. Frame starts are then exactly 11*`CLK_DIV` cycles apart.
- R9: `tx_idle` is 1 only when the buffer, the holding stage and the framing stage are all empty. While it is 1, `tx_line` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| tx_line | output | 1 | Serial output, high when quiet |
| fifo_full | output | 1 | Buffer has no free entry |
| tx_idle | output | 1 | All stages empty and line quiet |

## Verification
After a write edge, the byte reaches the holding stage one edge later and loads into the framing register on the following edge. The start bit is therefore first visible two edges after the write. Each later bit follows exactly `CLK_DIV` cycles after the one before it. `fifo_full` changes on the edge that fills or frees the last entry.

The bench keeps a cycle counter that advances on every rising edge. It drives inputs and samples outputs on falling edges. A write is logged by the counter value at the falling edge after its sampling edge. The serial monitor logs a frame start at the first falling edge where the line is low. It then reads each bit at its midpoint, half a bit period and then whole bit periods later. This allows the latency, the bit period and the back-to-back spacing to be compared with exact cycle counts.

// File: rtl/uart_tx_pkg.sv
// Shared types and frame construction for the buffered serial transmitter.
// Assumes an 8-bit payload, one start bit, even parity and one stop bit.
package uart_tx_pkg;
    localparam int unsigned DATA_BITS  = 8;
    localparam int unsigned FRAME_BITS = DATA_BITS + 3;

    typedef logic [DATA_BITS-1:0]  tx_byte_t;
    typedef logic [FRAME_BITS-1:0] tx_frame_t;

    // Frame image, bit 0 is sent first: start, data LSB first, parity, stop.
    function automatic tx_frame_t build_frame(input tx_byte_t d);
        return {1'b1, ^d, d, 1'b0};
    endfunction
endpackage

// File: rtl/tx_fifo.sv
// Circular first-in first-out byte buffer.
// A write is accepted only while not full. The reader must pop only while
// not empty. The head entry is presented combinationally.
module tx_fifo #(
    parameter int unsigned DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_req,
    input  uart_tx_pkg::tx_byte_t push_data,
    input  logic                  pop,
    output uart_tx_pkg::tx_byte_t head,
    output logic                  full,
    output logic                  empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    uart_tx_pkg::tx_byte_t mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign push  = push_req && !full;
    assign head  = mem[rd_ptr];

    // Storage write: no reset needed, validity is tracked by count.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop) |=> (count == $past(count)) && full);
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tx_baud_gen.sv
// Bit-period divider: emits a one-cycle tick every DIV clocks.
// A restart pulse realigns the period to the cycle after the pulse.
// Assumes DIV >= 2.
module tx_baud_gen #(
    parameter int unsigned DIV = 5208
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Count clocks within the current bit; wrap on tick or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tx_framer.sv
// Holding stage and framing shift register.
// The holding stage pulls from the buffer when it is empty. The shift
// register loads from the holding stage when it is free, or on the tick that
// ends a stop bit, which lets frames run back to back. The line is high when
// no frame is active.
module tx_framer (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_empty,
    input  uart_tx_pkg::tx_byte_t fifo_head,
    input  logic                  tick,
    output logic                  fifo_pop,
    output logic                  baud_restart,
    output logic                  line,
    output logic                  busy,
    output logic                  hold_valid
);
    import uart_tx_pkg::*;
    localparam int unsigned BW = $clog2(FRAME_BITS + 1);

    tx_byte_t      hold_q;
    tx_frame_t     shreg;
    logic [BW-1:0] bits_left;
    logic          last_bit, load;

    assign last_bit     = (bits_left == BW'(1));
    assign load         = hold_valid && (!busy || (tick && last_bit));
    assign fifo_pop     = !hold_valid && !fifo_empty;
    assign baud_restart = load;
    assign line         = busy ? shreg[0] : 1'b1;

    // Holding stage: fill from the buffer when empty, drain into the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_q     <= '0;
        end else if (fifo_pop) begin
            hold_valid <= 1'b1;
            hold_q     <= fifo_head;
        end else if (load) begin
            hold_valid <= 1'b0;
        end
    end

    // Framing shifter: load a frame, advance one bit per tick, free after stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            bits_left <= '0;
            busy      <= 1'b0;
        end else if (load) begin
            shreg     <= build_frame(hold_q);
            bits_left <= BW'(FRAME_BITS);
            busy      <= 1'b1;
        end else if (busy && tick) begin
            if (last_bit) begin
                busy <= 1'b0;
            end else begin
                shreg     <= {1'b1, shreg[FRAME_BITS-1:1]};
                bits_left <= bits_left - 1'b1;
            end
        end
    end

    assert_start_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (line == 1'b0));
    assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_bit) |-> line);
    assert_idle_line_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);
    assert_hold_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !load) |=> hold_valid && (hold_q == $past(hold_q)));
endmodule

// File: rtl/uart_tx_pipe.sv
// Buffered serial transmitter top: byte buffer, holding stage, framing
// shifter and bit-period divider.
// Assumes CLK_DIV >= 2 and FIFO_DEPTH >= 2. The reset is synchronous and
// active low.
module uart_tx_pipe #(
    parameter int unsigned CLK_DIV    = 5208,
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       tx_line,
    output logic       fifo_full,
    output logic       tx_idle
);
    import uart_tx_pkg::*;

    tx_byte_t head;
    logic     empty, pop, tick, restart, busy, hold_valid;

    tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(wr_en), .push_data(wr_data),
        .pop(pop), .head(head), .full(fifo_full), .empty(empty)
    );

    tx_baud_gen #(.DIV(CLK_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    tx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .fifo_empty(empty), .fifo_head(head),
        .tick(tick), .fifo_pop(pop), .baud_restart(restart), .line(tx_line),
        .busy(busy), .hold_valid(hold_valid)
    );

    assign tx_idle = empty && !hold_valid && !busy;

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx_line);
    assert_full_not_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !tx_idle);
endmodule

// File: tb/test_uart_tx_pipe.sv
module test_uart_tx_pipe;
    localparam int DIV    = 8;
    localparam int FRAME  = 11 * DIV;
    localparam int NVEC   = 8;
    // Each vector: {data byte, expected even parity bit}
    localparam logic [8:0] VEC [NVEC] = '{
        {8'h00, 1'b0}, {8'hFF, 1'b0}, {8'hA5, 1'b0}, {8'h01, 1'b1},
        {8'h80, 1'b1}, {8'h37, 1'b1}, {8'h5A, 1'b0}, {8'hC3, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_line, fifo_full, tx_idle;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [7:0] rx_data [$];
    logic       rx_par  [$];
    int         rx_start[$];
    logic [7:0] exp_q   [$];

    uart_tx_pipe #(.CLK_DIV(DIV), .FIFO_DEPTH(16)) i_uart_tx_pipe (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_line(tx_line), .fifo_full(fifo_full), .tx_idle(tx_idle)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        while (cyc < 20000 && !done) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 20000);
            finish_run();
        end
    end

    // Serial monitor: mid-bit sampling of each frame.
    initial begin
        logic [10:0] fb;
        int          s;
        forever begin
            @(negedge clk);
            if (rst_n && tx_line == 1'b0) begin
                s = cyc;
                repeat (DIV / 2) @(negedge clk);
                fb[0] = tx_line;
                for (int i = 1; i < 11; i++) begin
                    repeat (DIV) @(negedge clk);
                    fb[i] = tx_line;
                end
                check(fb[0] == 1'b0, "R5 start bit", fb[0], 0);
                check(fb[10] == 1'b1, "R5 stop bit", fb[10], 1);
                check(fb[9] == ^fb[8:1], "R5 even parity", fb[9], ^fb[8:1]);
                rx_data.push_back(fb[8:1]);
                rx_par.push_back(fb[9]);
                rx_start.push_back(s);
            end
        end
    end

    initial begin
        int wcyc, base, accepted;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line == 1'b1, "R1 line high", tx_line, 1);
        check(fifo_full == 1'b0, "R1 not full", fifo_full, 0);
        check(tx_idle == 1'b1, "R1 idle", tx_idle, 1);

        // Table walk: one byte at a time from idle.
        for (int i = 0; i < NVEC; i++) begin
            base = rx_data.size();
            wr_en = 1'b1; wr_data = VEC[i][8:1];
            @(negedge clk);
            wcyc = cyc; wr_en = 1'b0;
            check(tx_idle == 1'b0, "R9 busy after write", tx_idle, 0);
            wait (rx_data.size() == base + 1);
            check(rx_data[base] == VEC[i][8:1], "R2 data", rx_data[base], VEC[i][8:1]);
            check(rx_par[base] == VEC[i][0], "R5 parity table", rx_par[base], VEC[i][0]);
            check(rx_start[base] - wcyc == 2, "R7 start latency", rx_start[base] - wcyc, 2);
            repeat (DIV) @(negedge clk);
            check(tx_idle == 1'b1 && tx_line == 1'b1, "R9 idle after frame", tx_idle, 1);
        end

        // Burst: write every cycle until well past full.
        base = rx_data.size();
        accepted = 0;
        for (int i = 0; i < 20; i++) begin
            if (!fifo_full) begin
                accepted++;
                exp_q.push_back(8'(8'h10 + i));
            end
            wr_en = 1'b1; wr_data = 8'(8'h10 + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        check(accepted == 18, "R3 accepted before full", accepted, 18);
        check(fifo_full == 1'b1, "R3 full flag", fifo_full, 1);
        wr_en = 1'b1; wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0;
        check(fifo_full == 1'b1, "R4 still full after dropped write", fifo_full, 1);

        wait (tx_idle == 1'b1);
        repeat (2 * FRAME) @(negedge clk);
        check(rx_data.size() - base == 18, "R4 no extra frames", rx_data.size() - base, 18);
        for (int j = 0; j < 18; j++)
            check(rx_data[base + j] == exp_q[j], "R2 burst order", rx_data[base + j], exp_q[j]);
        for (int j = 1; j < 18; j++)
            check(rx_start[base + j] - rx_start[base + j - 1] == FRAME,
                  "R8 R6 back-to-back spacing",
                  rx_start[base + j] - rx_start[base + j - 1], FRAME);
        check(tx_idle == 1'b1 && tx_line == 1'b1 && fifo_full == 1'b0,
              "R9 final idle", tx_idle, 1);

        done = 1'b1;
        finish_run();
    end
endmodule